// File: doc/BRIEF.md
# Configurable Asynchronous Character Receiver

This block pulls characters off an asynchronous serial line that idles high. It works from a 16x oversampling tick supplied from outside and a run-time format shared with the matching transmitter. The format sets the character width (5 to 9 bits), the parity mode (none, even or odd) and a stop-bit count. A character is reported through a one-clock valid pulse. The pulse carries the character zero-extended to 9 bits, together with a parity-error flag and a frame-error flag.

The core is a five-state machine. ST_IDLE looks for a high-to-low change of the line at tick instants. ST_START confirms the start bit at its centre. ST_DATA collects the data bits. ST_PARITY takes the optional parity bit. ST_STOP samples the first stop bit.

The transitions are:
- IDLE→START on a falling edge.
- START→IDLE (glitch abort) when the centre sample is high.
- START→DATA when the centre sample is low.
- DATA→DATA between data bits.
- DATA→PARITY or DATA→STOP after the last data bit, depending on the parity mode.
- PARITY→STOP after the parity sample.
- STOP→IDLE after the stop sample.

The serial input first passes through a synchroniser with a configurable number of stages. Only the first stop bit is ever looked at, so a second stop bit plays no part in reception.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, rx_valid, rx_char, rx_frame_err and rx_parity_err are all 0.
- R2: A low level at a tick that follows a high level at the previous tick starts a candidate frame. The frame goes on only if the line is still low at the 8th tick after that; otherwise nothing is reported.
- R3: Data bits are taken least significant first, each sampled 16 ticks after the previous sample. The character width comes from cfg_data_bits (5 to 9), and rx_char bits above that width are 0.
- R4: cfg_parity encodes 2'b00 none, 2'b10 even, 2'b11 odd. With parity on, one parity bit follows the last data bit. The expected value is the XOR of the data bits, inverted for odd. rx_parity_err is 1 on a mismatch and is always 0 with parity off.
- R5: rx_frame_err is 1 exactly when the first stop bit is sampled low.
- R6: cfg_two_stop has no effect. After the first stop sample, the receiver looks for a new start edge at once, even when the second stop slot is taken by the next start bit.
- R7: rx_valid is a single-clock pulse in the clock after the first stop-bit sample. rx_char and both flags keep their values between pulses.
- R8: Back-to-back frames with no idle gap are all received.
- R9: A cfg_data_bits value below 5 acts as 5, and a value above 9 acts as 9.
- R10: The reserved cfg_parity code 2'b01 acts as parity off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Raw serial input, idles high |
| os_tick | input | 1 | One-clock pulse at 16x the bit rate |
| cfg_data_bits | input | 4 | Character width code |
| cfg_parity | input | 2 | Parity mode code |
| cfg_two_stop | input | 1 | Stop-bit count setting (not examined) |
| rx_char | output | 9 | Last received character, zero-extended |
| rx_valid | output | 1 | Character-ready pulse |
| rx_frame_err | output | 1 | First stop bit was low |
| rx_parity_err | output | 1 | Parity mismatch |

## Verification
A wrong state or a wrong tick count inside the receiver shifts every later sample point by whole bit periods. This shows up at the ports as a misplaced or missing rx_valid pulse within one frame time, usually together with a shifted character or a false frame error. A reference model counts ticks from the detected edge and is compared with the outputs on every clock, so a pulse one clock early or late is caught in the cycle it occurs. Directed frames then check each character's value and flags against values computed from the stimulus. They cover glitches, all widths, both parity senses, frame errors, clamped width codes and frames with no gap between them.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_RSVD = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_mode_e;

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign d_out = d_in;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '1;
                end else if (STAGES == 1) begin
                    chain[0] <= d_in;
                end else begin
                    chain <= {chain[STAGES-2:0], d_in};
                end
            end
            assign d_out = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sfr_fmt_decode.sv
module sfr_fmt_decode
    import sfr_pkg::*;
#(
    parameter int MIN_BITS = 5,
    parameter int MAX_BITS = 9,
    localparam int IW = $clog2(MAX_BITS + 1)
) (
    input  logic [IW-1:0] cfg_bits,
    input  logic [1:0]    cfg_par,
    output logic [IW-1:0] nbits,
    output logic          par_en,
    output logic          par_odd
);
    always_comb begin
        if (cfg_bits < IW'(MIN_BITS)) begin
            nbits = IW'(MIN_BITS);
        end else if (cfg_bits > IW'(MAX_BITS)) begin
            nbits = IW'(MAX_BITS);
        end else begin
            nbits = cfg_bits;
        end
        par_en  = (cfg_par == PAR_EVEN) || (cfg_par == PAR_ODD);
        par_odd = (cfg_par == PAR_ODD);
    end
endmodule

// File: rtl/sfr_parity.sv
module sfr_parity #(
    parameter int W = 9,
    localparam int IW = $clog2(W + 1)
) (
    input  logic [W-1:0]  data,
    input  logic [IW-1:0] nbits,
    input  logic          odd,
    output logic          expected
);
    always_comb begin
        expected = odd;
        for (int i = 0; i < W; i++) begin
            if (IW'(i) < nbits) begin
                expected = expected ^ data[i];
            end
        end
    end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import sfr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_BITS    = 5,
    parameter int MAX_BITS    = 9,
    parameter int OVS         = 16,
    localparam int IW   = $clog2(MAX_BITS + 1),
    localparam int CW   = $clog2(OVS),
    localparam int HALF = OVS / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_line,
    input  logic                os_tick,
    input  logic [IW-1:0]       cfg_data_bits,
    input  logic [1:0]          cfg_parity,
    input  logic                cfg_two_stop,
    output logic [MAX_BITS-1:0] rx_char,
    output logic                rx_valid,
    output logic                rx_frame_err,
    output logic                rx_parity_err
);
    rx_state_e           state;
    logic [CW-1:0]       cnt;
    logic [IW-1:0]       idx;
    logic [MAX_BITS-1:0] shreg;
    logic                pbit;
    logic                last_lvl;
    logic                ln;
    logic [IW-1:0]       nbits;
    logic                par_en;
    logic                par_odd;
    logic                par_exp;
    logic                bit_end;
    logic                stop_hit;
    logic                unused_two_stop;

    // The stop-bit count is deliberately never examined.
    assign unused_two_stop = cfg_two_stop;

    sfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_line),
        .d_out (ln)
    );

    sfr_fmt_decode #(.MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS)) u_fmt (
        .cfg_bits (cfg_data_bits),
        .cfg_par  (cfg_parity),
        .nbits    (nbits),
        .par_en   (par_en),
        .par_odd  (par_odd)
    );

    sfr_parity #(.W(MAX_BITS)) u_par (
        .data     (shreg),
        .nbits    (nbits),
        .odd      (par_odd),
        .expected (par_exp)
    );

    assign bit_end  = (cnt == CW'(OVS - 1));
    assign stop_hit = os_tick && (state == ST_STOP) && bit_end;

    // State register and sampling datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            idx      <= '0;
            shreg    <= '0;
            pbit     <= 1'b0;
            last_lvl <= 1'b1;
        end else if (os_tick) begin
            unique case (state)
                ST_IDLE: begin
                    last_lvl <= ln;
                    if (last_lvl && !ln) begin
                        state <= ST_START;
                        cnt   <= '0;
                        shreg <= '0;
                    end
                end
                ST_START: begin
                    if (cnt == CW'(HALF - 1)) begin
                        cnt <= '0;
                        if (ln) begin
                            state    <= ST_IDLE;
                            last_lvl <= 1'b1;
                        end else begin
                            state <= ST_DATA;
                            idx   <= '0;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        cnt        <= '0;
                        shreg[idx] <= ln;
                        if (idx == IW'(nbits - 1'b1)) begin
                            state <= par_en ? ST_PARITY : ST_STOP;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (bit_end) begin
                        cnt   <= '0;
                        pbit  <= ln;
                        state <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        cnt      <= '0;
                        state    <= ST_IDLE;
                        last_lvl <= ln;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid      <= 1'b0;
            rx_char       <= '0;
            rx_frame_err  <= 1'b0;
            rx_parity_err <= 1'b0;
        end else if (stop_hit) begin
            rx_valid      <= 1'b1;
            rx_char       <= shreg;
            rx_frame_err  <= !ln;
            rx_parity_err <= par_en && (pbit != par_exp);
        end else begin
            rx_valid <= 1'b0;
        end
    end

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_hold_char_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_char));

    p_char_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_char >> nbits) == '0));

    p_noparity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !par_en) |-> !rx_parity_err);

    p_data_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && $past(state) != ST_DATA)
            |-> ($past(state) == ST_START && !$past(ln)));

    p_stop_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> (state == ST_IDLE));

endmodule

// File: tb/test_serial_frame_rx.sv
module test_serial_frame_rx;
    localparam int TDIV = 4;
    localparam int BITCLK = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic [3:0] cfg_data_bits = 4'd8;
    logic [1:0] cfg_parity = 2'b00;
    logic       cfg_two_stop = 1'b0;
    logic [8:0] rx_char;
    logic       rx_valid;
    logic       rx_frame_err;
    logic       rx_parity_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    serial_frame_rx i_serial_frame_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_line       (rx_line),
        .os_tick       (os_tick),
        .cfg_data_bits (cfg_data_bits),
        .cfg_parity    (cfg_parity),
        .cfg_two_stop  (cfg_two_stop),
        .rx_char       (rx_char),
        .rx_valid      (rx_valid),
        .rx_frame_err  (rx_frame_err),
        .rx_parity_err (rx_parity_err)
    );

    // tick generator
    int tdiv_cnt = 0;
    always @(negedge clk) begin
        os_tick  <= (tdiv_cnt == 0);
        tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    end

    // Behavioural reference: counts ticks from the detected edge.
    bit   h0 = 1, h1 = 1, m_ln;
    bit   m_busy = 0, m_last = 1;
    int   m_t = 0;
    bit   m_bits [9];
    bit   m_pbit = 0;
    bit   m_valid = 0, m_fe = 0, m_pe = 0;
    int   m_char = 0;

    function automatic int eff_bits(input int code);
        if (code < 5) return 5;
        if (code > 9) return 9;
        return code;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            h0 = 1; h1 = 1; m_busy = 0; m_last = 1; m_t = 0;
            m_valid = 0; m_fe = 0; m_pe = 0; m_char = 0; m_pbit = 0;
        end else begin
            m_ln = h1; h1 = h0; h0 = rx_line;
            m_valid = 0;
            if (os_tick) begin
                if (!m_busy) begin
                    if (!m_ln && m_last) begin
                        m_busy = 1; m_t = 0;
                        for (int i = 0; i < 9; i++) m_bits[i] = 0;
                    end
                    m_last = m_ln;
                end else begin
                    m_t++;
                    if (m_t == 8) begin
                        if (m_ln) begin m_busy = 0; m_last = 1; end
                    end else if (m_t > 8 && (m_t - 8) % 16 == 0) begin
                        int k, nb, par;
                        bit pon, x;
                        k = (m_t - 8) / 16;
                        nb = eff_bits(int'(cfg_data_bits));
                        pon = cfg_parity[1];
                        if (k <= nb) m_bits[k-1] = m_ln;
                        else if (pon && k == nb + 1) m_pbit = m_ln;
                        else begin
                            x = cfg_parity[0];
                            m_char = 0;
                            for (int i = 0; i < nb; i++) begin
                                m_char = m_char | (int'(m_bits[i]) << i);
                                x = x ^ m_bits[i];
                            end
                            par = 0;
                            m_valid = 1;
                            m_fe = !m_ln;
                            m_pe = pon && (m_pbit != x);
                            m_busy = 0;
                            m_last = m_ln;
                        end
                    end
                end
            end
        end
    end

    // per-clock comparison and capture
    logic [10:0] got_q[$];
    logic [10:0] exp_q[$];

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (rx_valid !== m_valid) begin
                n_bad++;
                $display("FAIL R7 valid timing: actual %0b expected %0b at %0t", rx_valid, m_valid, $time);
            end
            if (rx_char !== 9'(m_char)) begin
                n_bad++;
                $display("FAIL R3 char: actual %h expected %h at %0t", rx_char, 9'(m_char), $time);
            end
            if (rx_frame_err !== m_fe) begin
                n_bad++;
                $display("FAIL R5 frame err: actual %0b expected %0b", rx_frame_err, m_fe);
            end
            if (rx_parity_err !== m_pe) begin
                n_bad++;
                $display("FAIL R4 parity err: actual %0b expected %0b", rx_parity_err, m_pe);
            end
            if (rx_valid) got_q.push_back({rx_parity_err, rx_frame_err, rx_char});
        end
    end

    task automatic hold_bit(input bit b);
        rx_line = b;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic idle_bits(input int n);
        rx_line = 1;
        repeat (n * BITCLK) @(negedge clk);
    endtask

    // par: 0 none, 1 even, 2 odd
    task automatic send(input logic [8:0] d, input int nb, input int par,
                        input bit flip_par, input bit stop1, input int stops);
        bit x;
        logic [8:0] masked;
        masked = d & 9'((1 << nb) - 1);
        x = (par == 2);
        hold_bit(0);
        for (int i = 0; i < nb; i++) begin
            hold_bit(d[i]);
            x = x ^ d[i];
        end
        if (par != 0) hold_bit(x ^ flip_par);
        hold_bit(stop1);
        for (int i = 1; i < stops; i++) hold_bit(1);
        exp_q.push_back({(par != 0) && flip_par, !stop1, masked});
    endtask

    task automatic check_frames(input string tag);
        idle_bits(2);
        n_cmp++;
        if (got_q.size() != exp_q.size()) begin
            n_bad++;
            $display("FAIL %s frame count: actual %0d expected %0d", tag, got_q.size(), exp_q.size());
        end else begin
            while (exp_q.size() > 0) begin
                logic [10:0] a, e;
                a = got_q.pop_front();
                e = exp_q.pop_front();
                n_cmp++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s frame {pe,fe,char}: actual %h expected %h", tag, a, e);
                end
            end
        end
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic set_cfg(input logic [3:0] b, input logic [1:0] p, input bit ts);
        @(negedge clk);
        cfg_data_bits = b;
        cfg_parity = p;
        cfg_two_stop = ts;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if ({rx_valid, rx_char, rx_frame_err, rx_parity_err} !== 12'd0) begin
            n_bad++;
            $display("FAIL R1 reset outputs: actual %h expected 0",
                     {rx_valid, rx_char, rx_frame_err, rx_parity_err});
        end
        rst_n = 1;
        idle_bits(2);

        // R3: 8 data bits, no parity
        set_cfg(4'd8, 2'b00, 0);
        send(9'h0A5, 8, 0, 0, 1, 1);
        send(9'h03C, 8, 0, 0, 1, 1);
        check_frames("R3");

        // R3 / R4: 5 bits even parity, correct
        set_cfg(4'd5, 2'b10, 0);
        send(9'h016, 5, 1, 0, 1, 1);
        check_frames("R4");

        // R4: 7 bits odd parity, corrupted parity bit
        set_cfg(4'd7, 2'b11, 0);
        send(9'h05B, 7, 2, 1, 1, 1);
        send(9'h011, 7, 2, 0, 1, 1);
        check_frames("R4");

        // R3: 9 bits odd parity
        set_cfg(4'd9, 2'b11, 0);
        send(9'h1C3, 9, 2, 0, 1, 1);
        check_frames("R3");

        // R5: first stop bit low
        set_cfg(4'd8, 2'b00, 0);
        send(9'h081, 8, 0, 0, 0, 1);
        idle_bits(1);
        send(9'h07E, 8, 0, 0, 1, 1);
        check_frames("R5");

        // R2: short glitch gives no character
        rx_line = 0;
        repeat (3 * TDIV) @(negedge clk);
        check_frames("R2");

        // R6 / R8: two-stop mode, next start in second stop slot
        set_cfg(4'd8, 2'b10, 1);
        send(9'h0FF, 8, 1, 0, 1, 1);
        send(9'h000, 8, 1, 0, 1, 1);
        send(9'h06D, 8, 1, 0, 1, 2);
        check_frames("R6");

        // R8: back-to-back 6-bit frames
        set_cfg(4'd6, 2'b00, 0);
        send(9'h02A, 6, 0, 0, 1, 1);
        send(9'h015, 6, 0, 0, 1, 1);
        send(9'h03F, 6, 0, 0, 1, 1);
        check_frames("R8");

        // R9: width codes out of range
        set_cfg(4'd2, 2'b00, 0);
        send(9'h01D, 5, 0, 0, 1, 1);
        check_frames("R9");
        set_cfg(4'd15, 2'b10, 0);
        send(9'h155, 9, 1, 1, 1, 1);
        check_frames("R9");

        // R10: reserved parity code acts as none
        set_cfg(4'd8, 2'b01, 0);
        send(9'h0C4, 8, 0, 0, 1, 1);
        check_frames("R10");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule